// File: doc/BRIEF.md
# Streaming-write receive packet sink

This block terminates streaming-write request packets on the user side of a receive path. Each packet arrives as a 115-bit header on one valid/ready stream and as a 128-bit payload on a second valid/ready stream. The payload stream carries start, end and empty markers. The block joins the header with the first payload beat of the same packet and checks that the packet is a streaming write on virtual channel 0. It then stores the payload bytes into a local byte-addressed memory at the address the header gives.

When the last beat has been taken, the block raises a one-cycle completion pulse. The pulse carries the counted byte total, the packet priority, both device IDs and the starting byte address. It also carries two error flags: one for a wrong packet class and one for a byte total that differs from the header's size field. A packet of the wrong class is still drained to its end, but none of its bytes reach memory. The memory has a combinational read port, which the rest of the design uses to fetch the stored data.

Back-pressure rules:
- A word moves on either stream only in a cycle where that stream's valid and ready are both high.
- While idle, header ready is high. Payload ready follows header valid, so a start beat can only be taken together with its header.
- Once a header is taken, header ready stays low until the end beat of that packet is consumed.
- Payload ready stays high for the rest of the packet. The sender may leave gaps between beats.

Top module: `swr_rx_sink`

## Requirements
- R1: After reset, hdr_ready is 1, cpl_valid is 0, and pay_ready is 0 while hdr_valid is 0.
- R2: In the idle state, pay_ready equals hdr_valid, so the header and the start beat of a packet are accepted in the same cycle.
- R3: After a header is accepted without an end beat in the same cycle, hdr_ready is 0 and pay_ready is 1 until the end beat is accepted. In the cycle after that, hdr_ready is 1 again.
- R4: The completion reports the following header fields:
  - cpl_prio from header bits [103:102].
  - cpl_dest from bits [95:80].
  - cpl_src from bits [79:64].
  - cpl_addr as {bits[33:32], bits[63:35], 3'b000}: the two extended bits above the 29-bit double-word address, in byte units.
- R5: Byte lane i of beat k (data bits [127-8i -: 8], the most significant byte first) is written to memory address (base + 16k + i) modulo 2^MEM_AW. Here base is cpl_addr.
- R6: On the end beat, pay_empty counts unused 2-byte segments at the least significant end of the data word. The lowest 2*pay_empty bytes are not written. The byte total is 16 times the beat count minus 2*pay_empty.
- R7: cpl_valid is high for exactly the one cycle after the end beat is accepted, and cpl_bytes carries the byte total then.
- R8: cpl_size_err is 1 when the byte total differs from header bits [114:106], and 0 otherwise. Bytes are still written when only this flag is set.
- R9: cpl_type_err is 1 when header bits [99:96] are not 6 or bit [105] is 1. Such a packet is still drained to its end beat, and no memory byte changes.
- R10: rd_data equals the memory byte at rd_addr, with no clock delay.
- R11: Gaps of any length between payload beats do not change the stored bytes or the completion values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hdr_valid | input | 1 | Header word valid |
| hdr_ready | output | 1 | Header word accepted when high with valid |
| hdr_data | input | 115 | Packet header |
| pay_valid | input | 1 | Payload beat valid |
| pay_ready | output | 1 | Payload beat accepted when high with valid |
| pay_data | input | 128 | Payload beat, first byte in bits [127:120] |
| pay_sop | input | 1 | First beat of packet |
| pay_eop | input | 1 | Last beat of packet |
| pay_empty | input | 3 | Unused 2-byte segments on the last beat |
| rd_addr | input | MEM_AW | Memory read address |
| rd_data | output | 8 | Memory byte at rd_addr |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_bytes | output | 12 | Counted payload bytes |
| cpl_size_err | output | 1 | Byte total differs from header size |
| cpl_type_err | output | 1 | Wrong packet class or channel |
| cpl_prio | output | 2 | Packet priority |
| cpl_dest | output | 16 | Destination ID |
| cpl_src | output | 16 | Source ID |
| cpl_addr | output | 34 | Starting byte address |

## Verification
The assertions assume the sender raises hdr_valid only together with a start beat. They also assume pay_sop is set only on the first beat of a packet and pay_empty is non-zero only on an end beat. The stimulus builds every packet from a byte length and derives the beat count and the empty value from it, so those rules always hold. Random gaps are placed only between payload beats, never between a header and its start beat.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int HDR_W   = 115;
  localparam int DATA_W  = 128;
  localparam int LANES   = DATA_W / 8;
  localparam int EMPTY_W = 3;
  localparam int CNT_W   = 12;
  localparam int ADDR_W  = 34;
  localparam logic [3:0] FTYPE_STREAM = 4'd6;

  typedef struct packed {
    logic [8:0]  size;
    logic        vc;
    logic        crf;
    logic [1:0]  prio;
    logic [1:0]  tt;
    logic [3:0]  ftype;
    logic [15:0] dest;
    logic [15:0] src;
    logic [28:0] dw_addr;
    logic [1:0]  xam;
  } hdr_t;
endpackage

// File: rtl/swr_hdr_decode.sv
module swr_hdr_decode
  import swr_pkg::*;
(
  input  logic [HDR_W-1:0]  raw,
  output hdr_t              fld,
  output logic [ADDR_W-1:0] byte_addr,
  output logic              bad
);
  always_comb begin
    fld.size    = raw[114:106];
    fld.vc      = raw[105];
    fld.crf     = raw[104];
    fld.prio    = raw[103:102];
    fld.tt      = raw[101:100];
    fld.ftype   = raw[99:96];
    fld.dest    = raw[95:80];
    fld.src     = raw[79:64];
    fld.dw_addr = raw[63:35];
    fld.xam     = raw[33:32];
  end

  assign byte_addr = {fld.xam, fld.dw_addr, 3'b000};
  assign bad       = (fld.ftype != FTYPE_STREAM) || fld.vc;
endmodule

// File: rtl/swr_lane_mask.sv
module swr_lane_mask
  import swr_pkg::*;
(
  input  logic               last,
  input  logic [EMPTY_W-1:0] empty,
  output logic [LANES-1:0]   en,
  output logic [5:0]         nbytes
);
  logic [5:0] valid_lanes;
  assign valid_lanes = last ? (6'(LANES) - {2'b00, empty, 1'b0}) : 6'(LANES);
  assign nbytes      = valid_lanes;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign en[i] = (6'(i) < valid_lanes);
  end
endmodule

// File: rtl/swr_byte_mem.sv
module swr_byte_mem
  import swr_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic [MEM_AW-1:0] base,
  input  logic [DATA_W-1:0] wdata,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << MEM_AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (we[i]) mem[base + MEM_AW'(i)] <= wdata[DATA_W-1-8*i -: 8];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/swr_rx_sink.sv
module swr_rx_sink
  import swr_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hdr_valid,
  output logic               hdr_ready,
  input  logic [114:0]       hdr_data,
  input  logic               pay_valid,
  output logic               pay_ready,
  input  logic [127:0]       pay_data,
  input  logic               pay_sop,
  input  logic               pay_eop,
  input  logic [2:0]         pay_empty,
  input  logic [MEM_AW-1:0]  rd_addr,
  output logic [7:0]         rd_data,
  output logic               cpl_valid,
  output logic [11:0]        cpl_bytes,
  output logic               cpl_size_err,
  output logic               cpl_type_err,
  output logic [1:0]         cpl_prio,
  output logic [15:0]        cpl_dest,
  output logic [15:0]        cpl_src,
  output logic [33:0]        cpl_addr
);
  typedef enum logic {S_IDLE, S_BODY} st_t;
  st_t st_q;

  hdr_t              dec_h, hdr_q, cur_h;
  logic [ADDR_W-1:0] dec_addr, base_q, cur_base;
  logic              dec_bad, bad_q, cur_bad;
  logic [MEM_AW-1:0] wptr_q, cur_wptr;
  logic [CNT_W-1:0]  cnt_q, total;
  logic [LANES-1:0]  lane_en, mem_we;
  logic [5:0]        nbytes;
  logic              idle, pay_fire;

  swr_hdr_decode u_dec (
    .raw(hdr_data), .fld(dec_h), .byte_addr(dec_addr), .bad(dec_bad)
  );

  swr_lane_mask u_mask (
    .last(pay_eop), .empty(pay_empty), .en(lane_en), .nbytes(nbytes)
  );

  assign idle      = (st_q == S_IDLE);
  assign hdr_ready = idle;
  assign pay_ready = idle ? hdr_valid : 1'b1;
  assign pay_fire  = pay_valid && pay_ready;

  assign cur_h    = idle ? dec_h    : hdr_q;
  assign cur_bad  = idle ? dec_bad  : bad_q;
  assign cur_base = idle ? dec_addr : base_q;
  assign cur_wptr = idle ? dec_addr[MEM_AW-1:0] : wptr_q;
  assign total    = (idle ? '0 : cnt_q) + CNT_W'(nbytes);
  assign mem_we   = (pay_fire && !cur_bad) ? lane_en : '0;

  swr_byte_mem #(.MEM_AW(MEM_AW)) u_mem (
    .clk(clk), .we(mem_we), .base(cur_wptr), .wdata(pay_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      hdr_q  <= '0;
      bad_q  <= 1'b0;
      base_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else if (pay_fire) begin
      if (idle) begin
        hdr_q  <= dec_h;
        bad_q  <= dec_bad;
        base_q <= dec_addr;
      end
      if (pay_eop) begin
        st_q <= S_IDLE;
      end else begin
        st_q   <= S_BODY;
        cnt_q  <= total;
        wptr_q <= cur_wptr + MEM_AW'(LANES);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpl_valid    <= 1'b0;
      cpl_bytes    <= '0;
      cpl_size_err <= 1'b0;
      cpl_type_err <= 1'b0;
      cpl_prio     <= '0;
      cpl_dest     <= '0;
      cpl_src      <= '0;
      cpl_addr     <= '0;
    end else begin
      cpl_valid <= pay_fire && pay_eop;
      if (pay_fire && pay_eop) begin
        cpl_bytes    <= total;
        cpl_size_err <= (total != CNT_W'(cur_h.size));
        cpl_type_err <= cur_bad;
        cpl_prio     <= cur_h.prio;
        cpl_dest     <= cur_h.dest;
        cpl_src      <= cur_h.src;
        cpl_addr     <= cur_base;
      end
    end
  end
endmodule

// File: rtl/swr_rx_sink_chk.sv
module swr_rx_sink_chk #(
  parameter int MEM_AW = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hdr_valid,
  input logic         hdr_ready,
  input logic [114:0] hdr_data,
  input logic         pay_valid,
  input logic         pay_ready,
  input logic         pay_eop,
  input logic [15:0]  mem_we,
  input logic         cpl_valid,
  input logic [11:0]  cpl_bytes
);
  logic eop_fire;
  assign eop_fire = pay_valid && pay_ready && pay_eop;

  // R2
  join_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_ready && !hdr_valid) |-> !pay_ready);

  // R3
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && !eop_fire) |=> !hdr_ready);

  // R3
  body_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_ready |-> pay_ready);

  // R3
  hdr_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_fire |=> hdr_ready);

  // R7
  cpl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_fire |=> cpl_valid);

  // R7
  cpl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eop_fire |=> !cpl_valid);

  // R9
  bad_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && (hdr_data[99:96] != 4'd6 || hdr_data[105]))
      |-> (mem_we == '0));

  // R6
  even_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> !cpl_bytes[0]);
endmodule

bind swr_rx_sink swr_rx_sink_chk #(.MEM_AW(MEM_AW)) chk_i (.*);

// File: tb/swr_rx_sink_tb_top.sv
module swr_rx_sink_tb_top;
  localparam int AW = 8;
  localparam int MB = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic hdr_valid = 0, pay_valid = 0, pay_sop = 0, pay_eop = 0;
  logic [114:0] hdr_data = '0;
  logic [127:0] pay_data = '0;
  logic [2:0] pay_empty = '0;
  logic [AW-1:0] rd_addr = '0;
  logic hdr_ready, pay_ready, cpl_valid, cpl_size_err, cpl_type_err;
  logic [7:0] rd_data;
  logic [11:0] cpl_bytes;
  logic [1:0] cpl_prio;
  logic [15:0] cpl_dest, cpl_src;
  logic [33:0] cpl_addr;

  int tests = 0, fails = 0;
  logic [7:0] model [MB];
  bit known [MB];

  always #10 clk = ~clk;

  swr_rx_sink #(.MEM_AW(AW)) dut_i (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [114:0] mk_hdr(int sz, logic [3:0] ft, bit vc, logic [1:0] pr,
      logic [15:0] d, logic [15:0] s, logic [28:0] a, logic [1:0] x);
    logic [114:0] h = '0;
    h[114:106] = 9'(sz); h[105] = vc; h[103:102] = pr; h[99:96] = ft;
    h[95:80] = d; h[79:64] = s; h[63:35] = a; h[33:32] = x;
    return h;
  endfunction

  task automatic sweep(input string tag);
    bit ok = 1;
    int bad_a = 0;
    logic [7:0] bad_v = 0, bad_e = 0;
    for (int a = 0; a < MB; a++) begin
      if (known[a]) begin
        @(negedge clk); rd_addr = AW'(a); #1;
        if (rd_data !== model[a] && ok) begin
          ok = 0; bad_a = a; bad_v = rd_data; bad_e = model[a];
        end
      end
    end
    check(ok, $sformatf("%s mem[%0h]", tag, bad_a), bad_v, bad_e);
  endtask

  // n: real byte length (even), hsz: header size field
  task automatic send(input int n, input int hsz, input logic [3:0] ft, input bit vc,
      input logic [28:0] a, input logic [1:0] x, input int gap, input string tag);
    int beats = (n + 15) / 16;
    int emp = (beats * 16 - n) / 2;
    logic [1:0] pr = 2'($urandom);
    logic [15:0] d = 16'($urandom), s = 16'($urandom);
    bit bad = (ft != 4'd6) || vc;
    logic [AW-1:0] base = AW'({x, a, 3'b000});
    logic [33:0] ba = {x, a, 3'b000};
    for (int k = 0; k < beats; k++) begin
      logic [127:0] w = {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
      if (k > 0) begin
        hdr_valid = 0; pay_valid = 0;
        for (int g = 0; g < gap; g++) @(negedge clk);
      end
      pay_valid = 1; pay_sop = (k == 0); pay_eop = (k == beats - 1);
      pay_empty = (k == beats - 1) ? 3'(emp) : 3'd0;
      pay_data = w; hdr_valid = (k == 0);
      if (k == 0) hdr_data = mk_hdr(hsz, ft, vc, pr, d, s, a, x);
      #1;
      if (k == 0) check(pay_ready === 1'b1, {tag, " R2 joint accept"}, pay_ready, 1);
      else check(hdr_ready === 1'b0 && pay_ready === 1'b1, {tag, " R3 body ready"},
                 {hdr_ready, pay_ready}, 2'b01);
      @(posedge clk);
      if (!bad) begin
        int lim = (k == beats - 1) ? 16 - 2 * emp : 16;
        for (int i = 0; i < lim; i++) begin
          int ad = (int'(base) + 16 * k + i) % MB;
          model[ad] = w[127-8*i -: 8]; known[ad] = 1;
        end
      end
    end
    @(negedge clk);
    hdr_valid = 0; pay_valid = 0; pay_sop = 0; pay_eop = 0; pay_empty = 0;
    check(cpl_valid === 1'b1, {tag, " R7 cpl pulse"}, cpl_valid, 1);
    check(cpl_bytes === 12'(n), {tag, " R6 byte count"}, cpl_bytes, n);
    check(cpl_size_err === (n != hsz), {tag, " R8 size err"}, cpl_size_err, n != hsz);
    check(cpl_type_err === bad, {tag, " R9 type err"}, cpl_type_err, bad);
    check(cpl_prio === pr && cpl_dest === d && cpl_src === s && cpl_addr === ba,
          {tag, " R4 fields"}, {cpl_prio, cpl_dest, cpl_src, cpl_addr},
          {pr, d, s, ba});
    check(hdr_ready === 1'b1, {tag, " R3 header reopened"}, hdr_ready, 1);
    @(negedge clk);
    check(cpl_valid === 1'b0, {tag, " R7 single cycle"}, cpl_valid, 0);
  endtask

  initial begin
    #(20 * 150000);
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    #1;
    check(hdr_ready === 1 && pay_ready === 0 && cpl_valid === 0, "R1 reset",
          {hdr_ready, pay_ready, cpl_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk); #1;
    check(hdr_ready === 1 && pay_ready === 0 && cpl_valid === 0, "R1 after reset",
          {hdr_ready, pay_ready, cpl_valid}, 3'b100);
    // R6: 40 bytes, empty 4, low 8 bytes of last beat not written
    send(40, 40, 4'd6, 0, 29'h0AABBCC1 & 29'h1FFFFFF1, 2'b00, 0, "d40");
    sweep("R5 R6 d40");
    // single beat packet, start and end together
    send(16, 16, 4'd6, 0, 29'h4, 2'b01, 0, "d16");
    sweep("R5 single beat");
    // R8 size mismatch still writes
    send(32, 34, 4'd6, 0, 29'h8, 2'b00, 1, "dsz");
    sweep("R8 writes kept");
    // R9 wrong ftype over written region: memory unchanged
    send(32, 32, 4'd5, 0, 29'h8, 2'b00, 0, "dft");
    sweep("R9 ftype no write");
    send(48, 48, 4'd6, 1, 29'h0, 2'b00, 2, "dvc");
    sweep("R9 vc no write");
    // R5 wraparound at top of memory
    send(34, 34, 4'd6, 0, 29'h1F, 2'b10, 0, "dwrap");
    sweep("R5 wrap");
    // R11 random packets with gaps
    for (int p = 0; p < 24; p++) begin
      int n = 2 * (1 + int'($urandom % 40));
      int hs = ($urandom % 5 == 0) ? n + 2 : n;
      send(n, hs, ($urandom % 6 == 0) ? 4'd2 : 4'd6, 0, 29'($urandom), 2'($urandom),
           int'($urandom % 4), $sformatf("R11 rnd%0d", p));
    end
    sweep("R10 R11 final");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule